// File: doc/BRIEF.md
# LUT-Network Chromosome Fitness Evaluator

This block scores one candidate circuit for an evolutionary logic search. The candidate is a chromosome that describes a chain of small lookup tables. For each table it gives the table contents and, for each table input, a route. A route picks either a primary input variable or the output of a table that sits earlier in the chain. After an accepted start, the block walks through every input combination of the chosen variable count. It computes the output of the last table for each combination and compares that output with the ideal bit read from an external target truth-table memory. The number of agreeing rows is the fitness.

Each table stage is registered, so a vector spends one clock in every stage. New vectors enter the pipeline once per clock. The target memory is a plain read port with a fixed latency of one cycle and no back-pressure. The memory must return data in the cycle after the address. There is no streamed data at the block edge, so `start`, `done` and `fitness` are plain control and status pins. A chromosome that routes a table to itself or to a later table is rejected without a sweep. A variable count outside the supported range is also rejected this way.

Top module: `lutnet_fitness`

## Requirements
- R1: After reset, `done` is 0 and `fitness` is 0.
- R2: With default parameters the chromosome holds 4 tables of 4 inputs each, and every table occupies a 36-bit gene. Table i starts at bit 36*i. Its bits [15:0] are its contents, and input k forms bit k of the content address. Its bits [16+5k +: 5] are the route code of input k.
- R3: A route code from 0 to 15 selects variable number c, meaning bit c of the swept vector. A variable at or above the variable count therefore reads 0. Code 16+j selects the output of table j.
- R4: The chromosome is rejected if any route code of table i is 16+i or higher. This covers a table feeding itself, a later table, or a code that names no table. On rejection, `done` rises at the clock edge that accepts `start` and `fitness` is 0.
- R5: The chromosome is rejected in the same way as in R4 when `nvars` is 0 or greater than 16.
- R6: For an accepted chromosome, `fitness` equals the number of vectors in 0 .. 2^nvars-1 for which the last table's output equals the target bit at that address.
- R7: For an accepted chromosome, `done` is low from the accepting edge on and rises exactly 2^nvars + 5 clock edges after the accepting edge (the number of tables plus one). `fitness` holds its final value from then on.
- R8: `tgt_addr` carries the vector leaving the last-but-one stage, and `tgt_rd_en` flags it. The memory returns `tgt_bit` for that address at the next clock edge. `tgt_rd_en` is 0 while no sweep is in flight.
- R9: `start` is ignored while a sweep or its drain is in progress, including the edge at which `done` rises. The chromosome and variable count are captured at the accepting edge. `done` and `fitness` hold until the next accepted start.
- R10: An accepted start of a valid chromosome clears `done` and `fitness` at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to evaluate the presented chromosome |
| nvars | input | 5 | Number of input variables, 1 to 16 |
| chrom | input | 144 | Chromosome: table contents and route codes |
| tgt_rd_en | output | 1 | Target memory read strobe |
| tgt_addr | output | 16 | Target memory read address (input vector) |
| tgt_bit | input | 1 | Ideal output bit, one cycle after the address |
| fitness | output | 17 | Count of matching rows |
| done | output | 1 | Result valid, held until the next accepted start |

## Verification
Two functions can fall in the same cycle: the completion of a sweep, and the arrival of a new start request. The bench provokes this by raising `start` with a different chromosome so that it is sampled by the very edge at which `done` rises. It also raises `start` once in the middle of a sweep. In both cases a behavioural model predicts `done` on every clock, and the bench judges the outcome by `done` staying high and `fitness` keeping the score of the original chromosome on the following clock.

// File: rtl/lutnet_pkg.sv
package lutnet_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } sweep_state_t;
endpackage

// File: rtl/lutnet_route_check.sv
module lutnet_route_check #(
  parameter int NVAR_MAX = 16,
  parameter int NLUT     = 4,
  parameter int LUT_K    = 4,
  parameter int SEL_W    = 5,
  parameter int CELLS    = 16,
  parameter int GENE_W   = 36
) (
  input  logic [NLUT*GENE_W-1:0] chrom,
  output logic                   bad_route
);
  logic [SEL_W-1:0] code;

  // A table may only listen to variables or to tables strictly before it.
  always_comb begin
    bad_route = 1'b0;
    code      = '0;
    for (int i = 0; i < NLUT; i++) begin
      for (int k = 0; k < LUT_K; k++) begin
        code = chrom[i*GENE_W + CELLS + k*SEL_W +: SEL_W];
        if (int'(code) >= NVAR_MAX + i) bad_route = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lutnet_stage.sv
module lutnet_stage #(
  parameter int NVAR_MAX = 16,
  parameter int NLUT     = 4,
  parameter int LUT_K    = 4,
  parameter int SEL_W    = 5
) (
  input  logic [NVAR_MAX-1:0]      vec,
  input  logic [NLUT-1:0]          subs,
  input  logic [(1<<LUT_K)-1:0]    cells,
  input  logic [LUT_K*SEL_W-1:0]   routes,
  output logic                     y
);
  localparam int VW = $clog2(NVAR_MAX);
  localparam int LW = $clog2(NLUT);

  logic [LUT_K-1:0] addr;
  logic [SEL_W-1:0] code;
  logic [SEL_W-1:0] sub_idx;

  always_comb begin
    addr    = '0;
    code    = '0;
    sub_idx = '0;
    for (int k = 0; k < LUT_K; k++) begin
      code    = routes[k*SEL_W +: SEL_W];
      sub_idx = code - SEL_W'(NVAR_MAX);
      if (int'(code) < NVAR_MAX)
        addr[k] = vec[code[VW-1:0]];
      else if (int'(code) < NVAR_MAX + NLUT)
        addr[k] = subs[sub_idx[LW-1:0]];
      else
        addr[k] = 1'b0;
    end
    y = cells[addr];
  end
endmodule

// File: rtl/lutnet_fitness.sv
module lutnet_fitness
  import lutnet_pkg::*;
#(
  parameter int NVAR_MAX = 16,
  parameter int NLUT     = 4,
  parameter int LUT_K    = 4,
  localparam int CELLS   = 1 << LUT_K,
  localparam int SEL_W   = $clog2(NVAR_MAX + NLUT),
  localparam int GENE_W  = CELLS + LUT_K*SEL_W,
  localparam int CHROM_W = NLUT*GENE_W,
  localparam int NV_W    = $clog2(NVAR_MAX) + 1,
  localparam int FIT_W   = NVAR_MAX + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [NV_W-1:0]    nvars,
  input  logic [CHROM_W-1:0] chrom,
  output logic               tgt_rd_en,
  output logic [NVAR_MAX-1:0] tgt_addr,
  input  logic               tgt_bit,
  output logic [FIT_W-1:0]   fitness,
  output logic               done
);
  sweep_state_t state;
  logic [CHROM_W-1:0]  chrom_q;
  logic [NV_W-1:0]     nv_q;
  logic [NVAR_MAX-1:0] vcnt;
  logic [NVAR_MAX:0]   vnext;
  logic                last_vec;
  logic                bad_route, reject, accept;

  logic [NVAR_MAX-1:0] st_vec [NLUT];
  logic [NLUT-1:0]     st_sub [NLUT];
  logic [NLUT:0]       st_val, st_last;
  logic [NLUT-1:0]     lut_y;
  logic                net_out;

  lutnet_route_check #(
    .NVAR_MAX(NVAR_MAX), .NLUT(NLUT), .LUT_K(LUT_K),
    .SEL_W(SEL_W), .CELLS(CELLS), .GENE_W(GENE_W)
  ) u_check (
    .chrom(chrom), .bad_route(bad_route)
  );

  assign reject = bad_route || (nvars == '0) || (int'(nvars) > NVAR_MAX);
  assign accept = (state == ST_IDLE) && start;
  assign vnext  = {1'b0, vcnt} + 1'b1;
  assign last_vec = (vnext == (FIT_W'(1) << nv_q));

  // One registered stage per table.
  for (genvar s = 0; s < NLUT; s++) begin : g_stage
    lutnet_stage #(
      .NVAR_MAX(NVAR_MAX), .NLUT(NLUT), .LUT_K(LUT_K), .SEL_W(SEL_W)
    ) u_lut (
      .vec(st_vec[s]),
      .subs(st_sub[s]),
      .cells(chrom_q[s*GENE_W +: CELLS]),
      .routes(chrom_q[s*GENE_W + CELLS +: LUT_K*SEL_W]),
      .y(lut_y[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NLUT; s++) begin
        st_vec[s] <= '0;
        st_sub[s] <= '0;
      end
      st_val  <= '0;
      st_last <= '0;
      net_out <= 1'b0;
    end else begin
      st_vec[0]  <= vcnt;
      st_sub[0]  <= '0;
      st_val[0]  <= (state == ST_RUN);
      st_last[0] <= (state == ST_RUN) && last_vec;
      for (int s = 1; s < NLUT; s++) begin
        st_vec[s] <= st_vec[s-1];
        st_sub[s] <= st_sub[s-1] | (NLUT'(lut_y[s-1]) << (s-1));
      end
      for (int s = 1; s <= NLUT; s++) begin
        st_val[s]  <= st_val[s-1];
        st_last[s] <= st_last[s-1];
      end
      net_out <= lut_y[NLUT-1];
    end
  end

  assign tgt_addr  = st_vec[NLUT-1];
  assign tgt_rd_en = st_val[NLUT-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      chrom_q <= '0;
      nv_q    <= '0;
      vcnt    <= '0;
      fitness <= '0;
      done    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          fitness <= '0;
          if (reject) begin
            done <= 1'b1;
          end else begin
            done    <= 1'b0;
            chrom_q <= chrom;
            nv_q    <= nvars;
            vcnt    <= '0;
            state   <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (last_vec) state <= ST_DRAIN;
          else          vcnt  <= vcnt + 1'b1;
        end
        default: begin
          if (st_val[NLUT] && (net_out == tgt_bit)) fitness <= fitness + 1'b1;
          if (st_last[NLUT]) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
      endcase
      if (state == ST_RUN && st_val[NLUT] && (net_out == tgt_bit))
        fitness <= fitness + 1'b1;
    end
  end

  // R4, R5: a rejected request completes at once with a zero score.
  p_reject_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && reject) |=> (done && fitness == '0));

  // R10
  p_accept_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !reject) |=> (!done && fitness == '0));

  // R9
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !accept) |=> (done && $stable(fitness)));

  // R6
  p_fit_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fitness <= (FIT_W'(1) << nv_q)));

  // R7
  p_busy_not_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> !done);

  // R8
  p_rd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !done) |-> !tgt_rd_en);
endmodule

// File: tb/sim_lutnet_fitness.sv
`timescale 1ns/1ps
module sim_lutnet_fitness;
  localparam int NVAR_MAX = 16;
  localparam int NLUT     = 4;
  localparam int LUT_K    = 4;
  localparam int CELLS    = 16;
  localparam int SEL_W    = 5;
  localparam int GENE_W   = 36;
  localparam int CHROM_W  = NLUT*GENE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [4:0] nvars = 5'd1;
  logic [CHROM_W-1:0] chrom = '0;
  logic tgt_rd_en;
  logic [15:0] tgt_addr;
  logic tgt_bit = 1'b0;
  logic [16:0] fitness;
  logic done;

  int checks = 0;
  int fails  = 0;

  int tmode = 0;
  logic [CHROM_W-1:0] tchrom = '0;
  int unsigned tseed = 0;

  always #2 clk = ~clk;

  lutnet_fitness u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .nvars(nvars), .chrom(chrom),
    .tgt_rd_en(tgt_rd_en), .tgt_addr(tgt_addr), .tgt_bit(tgt_bit),
    .fitness(fitness), .done(done)
  );

  function automatic logic net_eval(input logic [CHROM_W-1:0] ch, input int unsigned v);
    logic [NLUT-1:0] sub;
    sub = '0;
    for (int i = 0; i < NLUT; i++) begin
      int unsigned a;
      a = 0;
      for (int k = 0; k < LUT_K; k++) begin
        int unsigned c;
        logic b;
        c = ch[i*GENE_W + CELLS + k*SEL_W +: SEL_W];
        if (c < 16) b = (v >> c) & 1;
        else        b = sub[c-16];
        a = a | (int'(b) << k);
      end
      sub[i] = ch[i*GENE_W + a];
    end
    return sub[NLUT-1];
  endfunction

  function automatic logic tgt_fn(input int unsigned v);
    int unsigned h;
    if (tmode == 0) return net_eval(tchrom, v);
    if (tmode == 2) return ((v & 1) & ((v >> 1) & 1)) != 0;
    h = (v ^ tseed) * 32'h9E3779B1;
    return h[17];
  endfunction

  always @(posedge clk) tgt_bit <= tgt_fn(tgt_addr);

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [CHROM_W-1:0] rand_chrom(input int nv);
    logic [CHROM_W-1:0] ch;
    ch = '0;
    for (int i = 0; i < NLUT; i++) begin
      ch[i*GENE_W +: CELLS] = 16'($urandom);
      for (int k = 0; k < LUT_K; k++) begin
        int unsigned c;
        if (i > 0 && ($urandom % 2) == 1) c = 16 + ($urandom % i);
        else if (($urandom % 8) == 0)     c = 15;
        else                              c = $urandom % nv;
        ch[i*GENE_W + CELLS + k*SEL_W +: SEL_W] = 5'(c);
      end
    end
    return ch;
  endfunction

  task automatic run(input logic [CHROM_W-1:0] ch, input int nv, input logic bad,
                     input int poke, input string tag);
    int L;
    int expf;
    expf = 0;
    if (!bad) for (int v = 0; v < (1 << nv); v++)
      if (net_eval(ch, v) == tgt_fn(v)) expf++;
    L = bad ? 0 : (1 << nv) + NLUT + 1;
    @(negedge clk);
    chrom = ch; nvars = 5'(nv); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c <= L + 1; c++) begin
      check(done == (c >= L), {tag, " R7 R9 done timing"}, int'(done), int'(c >= L));
      if (c == 0 && !bad) check(fitness == 0, {tag, " R10 clear"}, int'(fitness), 0);
      if (c >= L) check(fitness == expf, {tag, " R6 fitness"}, int'(fitness), expf);
      start = (poke != 0) && (c == 2 || c == L - 1);
      if (start) begin
        chrom = ~ch; nvars = 5'd2;
      end
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [CHROM_W-1:0] ch;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(fitness == 0, "R1 fitness after reset", int'(fitness), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && fitness == 0, "R1 idle after release", int'(done), 0);

    // R2 R3: hand-built AND of variables 0 and 1, passed along the chain.
    ch = '0;
    ch[0 +: 16] = 16'h0008;
    ch[16 +: 20] = {5'd15, 5'd15, 5'd1, 5'd0};
    for (int i = 1; i < NLUT; i++) begin
      ch[i*GENE_W +: 16] = 16'h0002;
      ch[i*GENE_W + 16 +: 20] = {5'd15, 5'd15, 5'd15, 5'(16 + i - 1)};
    end
    tmode = 2;
    run(ch, 3, 1'b0, 0, "R2 R3 and-chain");
    check(fitness == 8, "R2 R3 and-chain full score", int'(fitness), 8);

    ch = rand_chrom(1); tchrom = ch; tmode = 0;
    run(ch, 1, 1'b0, 0, "R6 nv1 self");
    ch = rand_chrom(5); tmode = 1; tseed = 32'h1234;
    run(ch, 5, 1'b0, 0, "R6 nv5 hash");
    ch = rand_chrom(8); tchrom = ch; tmode = 0;
    run(ch, 8, 1'b0, 1, "R9 nv8 busy start");
    ch = rand_chrom(11); tmode = 1; tseed = 32'h77;
    run(ch, 11, 1'b0, 1, "R8 nv11 hash");
    ch = rand_chrom(16); tmode = 1; tseed = 32'hBEEF;
    run(ch, 16, 1'b0, 0, "R6 nv16 hash");

    ch = rand_chrom(4);
    ch[2*GENE_W + 16 + 5 +: 5] = 5'd18;
    run(ch, 4, 1'b1, 0, "R4 self route");
    ch = rand_chrom(4);
    ch[0*GENE_W + 16 +: 5] = 5'd19;
    run(ch, 4, 1'b1, 0, "R4 forward route");
    ch = rand_chrom(4);
    ch[3*GENE_W + 16 + 15 +: 5] = 5'd31;
    run(ch, 4, 1'b1, 0, "R4 unnamed route");
    ch = rand_chrom(4);
    run(ch, 0, 1'b1, 0, "R5 zero vars");
    run(ch, 17, 1'b1, 0, "R5 too many vars");

    tchrom = ch; tmode = 0;
    run(ch, 4, 1'b0, 0, "R10 valid after reject");
    check(tgt_rd_en == 1'b0, "R8 read strobe idle", int'(tgt_rd_en), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule